// File: doc/BRIEF.md
# Programmable-Priority Shared Memory Arbiter

This block lets three requesters share one single-ported data memory: a processor core, a DMA engine and a debug agent. Each requester raises a request together with a write-enable, an address and write data. In the cycle a request wins, the block returns a grant for it. A requester that does not win sees no grant. It keeps its request and its data steady and tries again in the next cycle. Every granted access uses the memory for exactly one cycle. A granted read returns its data one cycle later, with a valid strobe that goes only to the requester that was granted.

The order of precedence comes from a 16-bit priority register, written through a small register port. The code 0x0020 raises the DMA engine above the core. Every other code, reserved values included, gives the default order: core first, then DMA. The debug agent always comes last. Software may rewrite the register at any time. A new code applies from the cycle after the write. The arbitration in the write cycle, and any access already granted, still follow the old code.

Top module: `prio_mem_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, no grant and no read-valid strobe is active, and the priority register reads 0x0000.
- R2: A lone request is granted in the same cycle in which it is presented.
- R3: At most one grant is active in any cycle, and a grant is only given to a requester whose request is high.
- R4: With the priority register at 0x0000, the core wins over the DMA engine, and both win over the debug agent.
- R5: With the priority register at 0x0020, the DMA engine wins over the core, and both win over the debug agent.
- R6: Any other register value (for example 0x0021 or 0xFFFF) arbitrates exactly like 0x0000, and the register reads back the value written.
- R7: The debug agent is granted only in cycles where neither the core nor the DMA engine requests.
- R8: A register write in cycle N changes the arbitration from cycle N+1 on. The grant given in cycle N follows the previous value.
- R9: A granted write (write-enable 1) stores its data at its address. A granted read (write-enable 0) returns the stored word in the next cycle, with a valid strobe on that requester's port only.
- R10: A requester that loses arbitration gets no grant and no valid strobe for that request. It is served in a later cycle once it wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| coreReq | input | 1 | Core access request |
| coreWe | input | 1 | Core write enable (1 write, 0 read) |
| coreAddr | input | ADDR_W | Core word address |
| coreWdata | input | DATA_W | Core write data |
| coreGnt | output | 1 | Core access granted this cycle |
| coreRvalid | output | 1 | Core read data valid |
| coreRdata | output | DATA_W | Core read data |
| dmaReq | input | 1 | DMA access request |
| dmaWe | input | 1 | DMA write enable |
| dmaAddr | input | ADDR_W | DMA word address |
| dmaWdata | input | DATA_W | DMA write data |
| dmaGnt | output | 1 | DMA access granted this cycle |
| dmaRvalid | output | 1 | DMA read data valid |
| dmaRdata | output | DATA_W | DMA read data |
| dbgReq | input | 1 | Debug agent access request |
| dbgWe | input | 1 | Debug agent write enable |
| dbgAddr | input | ADDR_W | Debug agent word address |
| dbgWdata | input | DATA_W | Debug agent write data |
| dbgGnt | output | 1 | Debug agent access granted this cycle |
| dbgRvalid | output | 1 | Debug agent read data valid |
| dbgRdata | output | DATA_W | Debug agent read data |
| cfgWe | input | 1 | Priority register write strobe |
| cfgWdata | input | 16 | Priority register write value |
| cfgRdata | output | 16 | Priority register current value |

## Verification
The arbiter is first tried with lone requests from each requester. This separates same-cycle granting and the read-data timing from any precedence effect. All three requesters then fire together under the codes 0x0000, 0x0020, 0x0021 and 0xFFFF. This tells the raised order apart from the default order, and shows that reserved codes fall back to the default. A final pattern keeps the core and the DMA engine busy while the register is rewritten in the middle of the burst and the debug agent waits. It shows the cycle in which the new order applies and confirms that the debug agent is starved while the others are busy.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  localparam int NUM_MASTERS = 3;
  localparam int IDX_CORE = 0;
  localparam int IDX_DMA = 1;
  localparam int IDX_DBG = 2;
  localparam int CFG_W = 16;
  localparam logic [CFG_W-1:0] RAISE_CODE = 16'h0020;
  localparam logic [CFG_W-1:0] DEFAULT_CODE = 16'h0000;

  typedef struct packed {
    logic [NUM_MASTERS-1:0] grant;
    logic wrEn;
    logic rdEn;
  } arbStrobe_t;
endpackage

// File: rtl/prio_arb_ctrl.sv
module prio_arb_ctrl
  import prio_arb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] reqVec,
  input  logic [NUM_MASTERS-1:0] weVec,
  input  logic                   cfgWe,
  input  logic [CFG_W-1:0]       cfgWdata,
  output logic [CFG_W-1:0]       cfgRdata,
  output arbStrobe_t             strobe
);
  logic [CFG_W-1:0] prioReg;
  logic dmaRaised;
  logic [NUM_MASTERS-1:0] grantVec;

  // The code is only sampled at the clock edge, so a write changes the
  // arbitration from the following cycle on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prioReg <= DEFAULT_CODE;
    else if (cfgWe) prioReg <= cfgWdata;
  end

  // Reserved codes decode to the default order.
  assign dmaRaised = (prioReg == RAISE_CODE);

  always_comb begin
    grantVec = '0;
    if (rst_n) begin
      if (dmaRaised) begin
        if (reqVec[IDX_DMA]) grantVec[IDX_DMA] = 1'b1;
        else if (reqVec[IDX_CORE]) grantVec[IDX_CORE] = 1'b1;
        else if (reqVec[IDX_DBG]) grantVec[IDX_DBG] = 1'b1;
      end else begin
        if (reqVec[IDX_CORE]) grantVec[IDX_CORE] = 1'b1;
        else if (reqVec[IDX_DMA]) grantVec[IDX_DMA] = 1'b1;
        else if (reqVec[IDX_DBG]) grantVec[IDX_DBG] = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.grant = grantVec;
    strobe.wrEn = |(grantVec & weVec);
    strobe.rdEn = |(grantVec & ~weVec);
  end

  assign cfgRdata = prioReg;
endmodule

// File: rtl/prio_arb_datapath.sv
module prio_arb_datapath
  import prio_arb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  arbStrobe_t                         strobe,
  input  logic [NUM_MASTERS-1:0][ADDR_W-1:0] addrVec,
  input  logic [NUM_MASTERS-1:0][DATA_W-1:0] wdataVec,
  output logic [NUM_MASTERS-1:0]             rvalidVec,
  output logic [DATA_W-1:0]                  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] selWdata;
  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DATA_W-1:0] rdataQ;

  // One-hot grant selects the winner's address and data.
  always_comb begin
    selAddr = '0;
    selWdata = '0;
    for (int m = 0; m < NUM_MASTERS; m++) begin
      if (strobe.grant[m]) begin
        selAddr = selAddr | addrVec[m];
        selWdata = selWdata | wdataVec[m];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) memArr[selAddr] <= selWdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdataQ <= '0;
    else if (strobe.rdEn) rdataQ <= memArr[selAddr];
  end

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : gRvalid
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rvalidVec[m] <= 1'b0;
      else rvalidVec[m] <= strobe.grant[m] & strobe.rdEn;
    end
  end

  assign rdata = rdataQ;
endmodule

// File: rtl/prio_mem_arbiter.sv
module prio_mem_arbiter
  import prio_arb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              coreReq,
  input  logic              coreWe,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreWdata,
  output logic              coreGnt,
  output logic              coreRvalid,
  output logic [DATA_W-1:0] coreRdata,
  input  logic              dmaReq,
  input  logic              dmaWe,
  input  logic [ADDR_W-1:0] dmaAddr,
  input  logic [DATA_W-1:0] dmaWdata,
  output logic              dmaGnt,
  output logic              dmaRvalid,
  output logic [DATA_W-1:0] dmaRdata,
  input  logic              dbgReq,
  input  logic              dbgWe,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic [DATA_W-1:0] dbgWdata,
  output logic              dbgGnt,
  output logic              dbgRvalid,
  output logic [DATA_W-1:0] dbgRdata,
  input  logic              cfgWe,
  input  logic [15:0]       cfgWdata,
  output logic [15:0]       cfgRdata
);
  logic [NUM_MASTERS-1:0] reqVec, weVec, rvalidVec;
  logic [NUM_MASTERS-1:0][ADDR_W-1:0] addrVec;
  logic [NUM_MASTERS-1:0][DATA_W-1:0] wdataVec;
  logic [DATA_W-1:0] rdShared;
  arbStrobe_t strobe;

  assign reqVec = {dbgReq, dmaReq, coreReq};
  assign weVec = {dbgWe, dmaWe, coreWe};
  assign addrVec = {dbgAddr, dmaAddr, coreAddr};
  assign wdataVec = {dbgWdata, dmaWdata, coreWdata};

  prio_arb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqVec(reqVec), .weVec(weVec),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .strobe(strobe)
  );

  prio_arb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .addrVec(addrVec),
    .wdataVec(wdataVec), .rvalidVec(rvalidVec), .rdata(rdShared)
  );

  assign coreGnt = strobe.grant[IDX_CORE];
  assign dmaGnt = strobe.grant[IDX_DMA];
  assign dbgGnt = strobe.grant[IDX_DBG];
  assign coreRvalid = rvalidVec[IDX_CORE];
  assign dmaRvalid = rvalidVec[IDX_DMA];
  assign dbgRvalid = rvalidVec[IDX_DBG];
  assign coreRdata = rdShared;
  assign dmaRdata = rdShared;
  assign dbgRdata = rdShared;
endmodule

// File: rtl/prio_arb_checker.sv
module prio_arb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        coreReq,
  input logic        coreWe,
  input logic        coreGnt,
  input logic        coreRvalid,
  input logic        dmaReq,
  input logic        dmaWe,
  input logic        dmaGnt,
  input logic        dmaRvalid,
  input logic        dbgReq,
  input logic        dbgWe,
  input logic        dbgGnt,
  input logic        dbgRvalid,
  input logic [15:0] cfgRdata
);
  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (!coreGnt && !dmaGnt && !dbgGnt);
  end

  assert_any_req_granted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (coreReq || dmaReq || dbgReq) |-> (coreGnt || dmaGnt || dbgGnt));

  assert_onehot_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({coreGnt, dmaGnt, dbgGnt}));

  assert_grant_has_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((coreGnt && !coreReq) || (dmaGnt && !dmaReq) || (dbgGnt && !dbgReq)) == 1'b0);

  assert_default_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgRdata != 16'h0020 && coreReq) |-> coreGnt);

  assert_raised_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgRdata == 16'h0020 && dmaReq) |-> dmaGnt);

  assert_dbg_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dbgGnt |-> (!coreReq && !dmaReq));

  assert_core_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (coreGnt && !coreWe) |=> coreRvalid);

  assert_dma_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dmaGnt && !dmaWe) |=> dmaRvalid);

  assert_dbg_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbgGnt && !dbgWe) |=> dbgRvalid);

  assert_rvalid_only_granted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({coreRvalid, dmaRvalid, dbgRvalid}) <= 1);
endmodule

bind prio_mem_arbiter prio_arb_checker u_checker (
  .clk(clk), .rst_n(rst_n),
  .coreReq(coreReq), .coreWe(coreWe), .coreGnt(coreGnt), .coreRvalid(coreRvalid),
  .dmaReq(dmaReq), .dmaWe(dmaWe), .dmaGnt(dmaGnt), .dmaRvalid(dmaRvalid),
  .dbgReq(dbgReq), .dbgWe(dbgWe), .dbgGnt(dbgGnt), .dbgRvalid(dbgRvalid),
  .cfgRdata(cfgRdata)
);

// File: tb/tb_prio_mem_arbiter.sv
`timescale 1ns/1ps
module tb_prio_mem_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] req = '0;
  logic [2:0] we = '0;
  logic [5:0] addr [3];
  logic [15:0] wdata [3];
  logic [2:0] gnt, rv;
  logic [15:0] rd [3];
  logic cfgWe = 1'b0;
  logic [15:0] cfgWdata = '0;
  logic [15:0] cfgRdata;

  int checks = 0;
  int errors = 0;

  typedef struct { logic isWr; logic [5:0] a; logic [15:0] d; } op_t;
  typedef struct { int m; logic [15:0] d; } rdExp_t;
  op_t opQ [3][$];
  rdExp_t rdQ [$];
  logic [15:0] model [64];
  logic [15:0] benchPrio = 16'h0000;
  logic [2:0] grantedLast = '0;
  bit prioJustChanged = 1'b0;

  always #2 clk = ~clk;

  prio_mem_arbiter dut (
    .clk(clk), .rst_n(rst_n),
    .coreReq(req[0]), .coreWe(we[0]), .coreAddr(addr[0]), .coreWdata(wdata[0]),
    .coreGnt(gnt[0]), .coreRvalid(rv[0]), .coreRdata(rd[0]),
    .dmaReq(req[1]), .dmaWe(we[1]), .dmaAddr(addr[1]), .dmaWdata(wdata[1]),
    .dmaGnt(gnt[1]), .dmaRvalid(rv[1]), .dmaRdata(rd[1]),
    .dbgReq(req[2]), .dbgWe(we[2]), .dbgAddr(addr[2]), .dbgWdata(wdata[2]),
    .dbgGnt(gnt[2]), .dbgRvalid(rv[2]), .dbgRdata(rd[2]),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: a granted request is dropped, then the next queued op is presented.
  always @(posedge clk) begin
    #1;
    for (int m = 0; m < 3; m++) begin
      if (req[m] && grantedLast[m]) req[m] = 1'b0;
      if (!req[m] && opQ[m].size() > 0) begin
        op_t o;
        o = opQ[m].pop_front();
        req[m] = 1'b1; we[m] = o.isWr; addr[m] = o.a; wdata[m] = o.d;
      end
    end
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] expG, expRv;
      logic [15:0] expD;
      int nReq;
      string tag;
      // read returns pushed last cycle (R9, R10)
      expRv = '0; expD = '0;
      while (rdQ.size() > 0) begin
        rdExp_t e;
        e = rdQ.pop_front();
        expRv[e.m] = 1'b1; expD = e.d;
      end
      check(rv == expRv, "R10 rvalid routing", {29'd0, rv}, {29'd0, expRv});
      for (int m = 0; m < 3; m++)
        if (expRv[m]) check(rd[m] == expD, "R9 read data", {16'd0, rd[m]}, {16'd0, expD});
      // expected grant from requirements
      expG = '0;
      nReq = req[0] + req[1] + req[2];
      if (benchPrio == 16'h0020) begin
        if (req[1]) expG[1] = 1'b1; else if (req[0]) expG[0] = 1'b1; else if (req[2]) expG[2] = 1'b1;
      end else begin
        if (req[0]) expG[0] = 1'b1; else if (req[1]) expG[1] = 1'b1; else if (req[2]) expG[2] = 1'b1;
      end
      if (nReq == 0) tag = "R3 no grant";
      else if (nReq == 1) tag = "R2 lone grant";
      else if (prioJustChanged) tag = "R8 new order";
      else if (req[2] && !gnt[2]) tag = "R7 debug lowest";
      else if (benchPrio == 16'h0020) tag = "R5 raised order";
      else if (benchPrio != 16'h0000) tag = "R6 reserved order";
      else tag = "R4 default order";
      check(gnt == expG, tag, {29'd0, gnt}, {29'd0, expG});
      for (int m = 0; m < 3; m++) begin
        if (expG[m]) begin
          if (we[m]) model[addr[m]] = wdata[m];
          else begin
            rdExp_t e;
            e.m = m; e.d = model[addr[m]];
            rdQ.push_back(e);
          end
        end
      end
      grantedLast = gnt;
      check(cfgRdata == benchPrio, "R6 register readback", {16'd0, cfgRdata}, {16'd0, benchPrio});
      prioJustChanged = 1'b0;
      if (cfgWe) begin
        prioJustChanged = (cfgWdata != benchPrio);
        benchPrio = cfgWdata;
      end
    end
  end

  task automatic push(input int m, input bit isWr, input logic [5:0] a, input logic [15:0] d);
    op_t o;
    o.isWr = isWr; o.a = a; o.d = d;
    opQ[m].push_back(o);
  endtask

  task automatic waitIdle();
    do @(negedge clk);
    while (opQ[0].size() + opQ[1].size() + opQ[2].size() > 0 || req != 3'b000);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic writeCfg(input logic [15:0] v);
    @(posedge clk); #1;
    cfgWe = 1'b1; cfgWdata = v;
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  task automatic collide(input logic [5:0] base);
    @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      push(m, 1'b0, base + 6'(m), 16'h0);
      push(m, 1'b1, base + 6'(m) + 6'd8, 16'hC000 + 16'(base) + 16'(m));
      push(m, 1'b0, base + 6'(m) + 6'd8, 16'h0);
    end
    waitIdle();
  endtask

  initial begin
    for (int m = 0; m < 3; m++) begin addr[m] = '0; wdata[m] = '0; end
    // R1: quiet during reset
    repeat (3) begin
      @(negedge clk);
      check(gnt == 3'b000 && rv == 3'b000, "R1 reset outputs", {26'd0, gnt, rv}, 32'd0);
      check(cfgRdata == 16'h0000, "R1 reset register", {16'd0, cfgRdata}, 32'd0);
    end
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check(gnt == 3'b000 && rv == 3'b000, "R1 after reset", {26'd0, gnt, rv}, 32'd0);
    // R2 / R9: lone accesses from each requester
    for (int m = 0; m < 3; m++) begin
      @(negedge clk);
      for (int k = 0; k < 8; k++) push(m, 1'b1, 6'(m * 8 + k), 16'hA000 + 16'(m * 16 + k));
      waitIdle();
    end
    for (int m = 0; m < 3; m++) begin
      @(negedge clk);
      for (int k = 0; k < 8; k++) push(m, 1'b0, 6'(((m + 1) % 3) * 8 + k), 16'h0);
      waitIdle();
    end
    // R4: default order
    collide(6'd0);
    // R5: raised DMA
    writeCfg(16'h0020);
    collide(6'd3);
    // R6: reserved codes fall back to default
    writeCfg(16'h0021);
    collide(6'd6);
    writeCfg(16'hFFFF);
    collide(6'd9);
    // R8 / R7: rewrite while core and DMA stream, debug waits
    writeCfg(16'h0000);
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      push(0, 1'b1, 6'd40 + 6'(k), 16'h5100 + 16'(k));
      push(1, 1'b1, 6'd48 + 6'(k), 16'h5200 + 16'(k));
    end
    push(2, 1'b0, 6'd40, 16'h0);
    repeat (3) @(negedge clk);
    writeCfg(16'h0020);
    repeat (2) @(negedge clk);
    writeCfg(16'h0000);
    waitIdle();
    @(negedge clk);
    for (int k = 0; k < 6; k++) push(2, 1'b0, 6'd48 + 6'(k), 16'h0);
    waitIdle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=%0t expected=completion", $time);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule